// File: doc/BRIEF.md
# Privilege-Checked Flag Register

This block keeps a 16-bit processor status word and carries out every operation that moves that word or part of it: copying the five arithmetic status bits out to a byte, writing them back from a byte, saving the whole word on a stack, restoring it from the stack, setting or clearing the interrupt enable, and restoring the word from a supplied value on return from an interrupt. It takes the current stack pointer as an input and reports the adjusted pointer with a write strobe. Stack traffic goes through a word-wide synchronous memory port.

Writes that reach the interrupt-enable bit (bit 9) or the two-bit I/O privilege field (bits 13:12) are filtered against a two-bit current privilege level, but only while the protected-mode input is high. A restore that may not touch one of these fields keeps the old value without complaint. A set or clear of the interrupt enable issued from too low a privilege raises a one-cycle fault and leaves the word alone.

An operation starts with a one-cycle `start` strobe and ends with a one-cycle `done` pulse. Every operation except the stack restore finishes one cycle after its strobe. The stack restore finishes two cycles after its strobe, because the memory returns read data one cycle after the request.

Top module: `psw_guard`

## Requirements
- R1: Once reset has been released, `flags`, `byte_out` and `sp_next` read zero, so the interrupt enable (bit 9) is clear, and `done`, `fault` and `sp_we` are low.
- R2: The byte-load operation (op 1) sets `byte_out` to the flag bits at positions 7, 6, 4, 2 and 0, each kept in the same position, with bits 5, 3 and 1 read as zero. `flags` does not change, and `done` rises in the cycle after the strobe.
- R3: The byte-store operation (op 2) copies bits 7, 6, 4, 2 and 0 of `src_word` into the same flag positions. All other flag bits keep their values.
- R4: The push operation (op 3) writes `flags` to address `sp_cur`-2 during the strobe cycle. In the next cycle `sp_next` equals `sp_cur`-2 with `sp_we` high, and `flags` has not changed.
- R5: The pop operation (op 4) requests a read at `sp_cur` during the strobe cycle. It loads the returned word, filtered as R6 and R7 describe, into `flags`. Two cycles after the strobe it presents `sp_next` = `sp_cur`+2 with `sp_we` and `done` high, and `done` stays low in the cycle in between.
- R6: On pop (op 4) or interrupt return (op 7, restore from `src_word`), flag bits 13:12 take the new value only when `prot_mode` is low or `cpl` is 0. Otherwise they keep the old value.
- R7: On pop or interrupt return, bit 9 takes the new value only when `prot_mode` is low or `cpl` is less than or equal to the current bits 13:12. Otherwise it keeps the old value, and `fault` stays low.
- R8: Set-enable (op 5) and clear-enable (op 6) write 1 or 0 to bit 9. When `prot_mode` is high and `cpl` is greater than bits 13:12, they instead pulse `fault` together with `done` and leave `flags` unchanged.
- R9: A `start` strobe that arrives while a pop is waiting for its read data is ignored. It causes no memory access, no flag change and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 3 | Operation: 0 none, 1 byte-load, 2 byte-store, 3 push, 4 pop, 5 set-enable, 6 clear-enable, 7 interrupt return |
| cpl | input | 2 | Current privilege level, 0 most privileged |
| prot_mode | input | 1 | High enables privilege filtering |
| src_word | input | 16 | Byte source (bits 7:0) or interrupt-return word |
| sp_cur | input | AW | Current stack pointer |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_re` |
| flags | output | 16 | Status word |
| byte_out | output | 8 | Result of byte-load |
| sp_next | output | AW | Updated stack pointer |
| sp_we | output | 1 | Stack pointer update strobe |
| mem_addr | output | AW | Stack memory address |
| mem_wdata | output | 16 | Stack memory write data |
| mem_we | output | 1 | Stack memory write request |
| mem_re | output | 1 | Stack memory read request |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Protection fault pulse |

## Verification
The properties assume that `op`, `cpl`, `prot_mode`, `src_word` and `sp_cur` are stable during the strobe cycle. For a pop, they also assume the memory delivers the word addressed in the request cycle on the cycle that follows. The bench drives every input on the falling edge and holds it through the next rising edge. Its stack model is a synchronous array that answers a read exactly one cycle after the request. The only strobe it issues during a pending pop is the deliberate one that tests R9.

// File: rtl/psw_guard_pkg.sv
package psw_guard_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_LDB  = 3'd1,
    OP_STB  = 3'd2,
    OP_PUSH = 3'd3,
    OP_POP  = 3'd4,
    OP_STI  = 3'd5,
    OP_CLI  = 3'd6,
    OP_IRET = 3'd7
  } psw_op_e;

  localparam int FW      = 16;
  localparam int BW      = 8;
  localparam int PLW     = 2;
  localparam int IE_BIT  = 9;
  localparam int PL_LO   = 12;
  localparam int PL_HI   = PL_LO + PLW - 1;
  localparam logic [BW-1:0] XFER_MASK = 8'hD5;

endpackage

// File: rtl/psw_perm.sv
module psw_perm
  import psw_guard_pkg::*;
(
  input  logic           prot,
  input  logic [PLW-1:0] cpl,
  input  logic [PLW-1:0] pl,
  output logic           may_ie,
  output logic           may_pl,
  output logic           trap_ie
);

  always_comb begin
    may_ie  = !prot || (cpl <= pl);
    may_pl  = !prot || (cpl == '0);
    trap_ie = prot && (cpl > pl);
  end

endmodule

// File: rtl/psw_merge.sv
module psw_merge
  import psw_guard_pkg::*;
(
  input  psw_op_e       kind,
  input  logic [FW-1:0] cur,
  input  logic [FW-1:0] src,
  input  logic [FW-1:0] rest,
  input  logic          may_ie,
  input  logic          may_pl,
  input  logic          trap_ie,
  output logic [FW-1:0] nxt
);

  logic [BW-1:0] low_mix;

  for (genvar b = 0; b < BW; b++) begin : g_low
    if (XFER_MASK[b]) begin : g_take
      assign low_mix[b] = src[b];
    end else begin : g_keep
      assign low_mix[b] = cur[b];
    end
  end

  always_comb begin
    nxt = cur;
    case (kind)
      OP_STB: nxt[BW-1:0] = low_mix;
      OP_STI: if (!trap_ie) nxt[IE_BIT] = 1'b1;
      OP_CLI: if (!trap_ie) nxt[IE_BIT] = 1'b0;
      OP_POP, OP_IRET: begin
        nxt = rest;
        if (!may_ie) nxt[IE_BIT] = cur[IE_BIT];
        if (!may_pl) nxt[PL_HI:PL_LO] = cur[PL_HI:PL_LO];
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/psw_stack_port.sv
module psw_stack_port
  import psw_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_push,
  input  logic           go_pop,
  input  logic [AW-1:0]  sp_cur,
  input  logic [FW-1:0]  flags,
  input  logic [PLW-1:0] cpl,
  input  logic           prot,
  output logic [AW-1:0]  mem_addr,
  output logic [FW-1:0]  mem_wdata,
  output logic           mem_we,
  output logic           mem_re,
  output logic           pend_q,
  output logic [AW-1:0]  pend_sp_q,
  output logic [PLW-1:0] pend_cpl_q,
  output logic           pend_prot_q
);

  localparam int STEP = FW / 8;
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic           pend_d;
  logic [AW-1:0]  pend_sp_d;
  logic [PLW-1:0] pend_cpl_d;
  logic           pend_prot_d;

  always_comb begin
    mem_we    = go_push;
    mem_re    = go_pop;
    mem_wdata = flags;
    mem_addr  = go_push ? (sp_cur - STEP_V) : sp_cur;
  end

  always_comb begin
    pend_d      = go_pop;
    pend_sp_d   = pend_sp_q;
    pend_cpl_d  = pend_cpl_q;
    pend_prot_d = pend_prot_q;
    if (go_pop) begin
      pend_sp_d   = sp_cur + STEP_V;
      pend_cpl_d  = cpl;
      pend_prot_d = prot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_sp_q   <= '0;
      pend_cpl_q  <= '0;
      pend_prot_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (go_pop) begin
        pend_sp_q   <= pend_sp_d;
        pend_cpl_q  <= pend_cpl_d;
        pend_prot_q <= pend_prot_d;
      end
    end
  end

endmodule

// File: rtl/psw_guard.sv
module psw_guard
  import psw_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [1:0]    cpl,
  input  logic          prot_mode,
  input  logic [15:0]   src_word,
  input  logic [AW-1:0] sp_cur,
  input  logic [15:0]   mem_rdata,
  output logic [15:0]   flags,
  output logic [7:0]    byte_out,
  output logic [AW-1:0] sp_next,
  output logic          sp_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  output logic          done,
  output logic          fault
);

  localparam logic [AW-1:0] STEP_V = AW'(FW / 8);

  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  psw_op_e        op_in;
  psw_op_e        kind;
  logic           accept;
  logic           go_push, go_pop;
  logic           pend_q, pend_prot_q;
  logic [AW-1:0]  pend_sp_q;
  logic [PLW-1:0] pend_cpl_q;
  logic           eff_prot;
  logic [PLW-1:0] eff_cpl;
  logic [FW-1:0]  rest_word;
  logic           may_ie, may_pl, trap_ie;

  logic [FW-1:0] flags_q, flags_d;
  logic [BW-1:0] byte_q, byte_d;
  logic [AW-1:0] sp_q, sp_d;
  logic          sp_we_q, sp_we_d;
  logic          done_q, done_d;
  logic          fault_q, fault_d;
  logic          byte_en;

  always_comb begin
    op_in   = psw_op_e'(op);
    accept  = start && !pend_q;
    go_push = accept && (op_in == OP_PUSH);
    go_pop  = accept && (op_in == OP_POP);
    if (pend_q)                        kind = OP_POP;
    else if (accept && !go_pop)        kind = op_in;
    else                               kind = OP_NOP;
    eff_prot  = pend_q ? pend_prot_q : prot_mode;
    eff_cpl   = pend_q ? pend_cpl_q  : cpl;
    rest_word = pend_q ? mem_rdata   : src_word;
  end

  psw_stack_port #(.AW(AW)) u_stack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .go_push    (go_push),
    .go_pop     (go_pop),
    .sp_cur     (sp_cur),
    .flags      (flags_q),
    .cpl        (cpl),
    .prot       (prot_mode),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .pend_q     (pend_q),
    .pend_sp_q  (pend_sp_q),
    .pend_cpl_q (pend_cpl_q),
    .pend_prot_q(pend_prot_q)
  );

  psw_perm u_perm (
    .prot   (eff_prot),
    .cpl    (eff_cpl),
    .pl     (flags_q[PL_HI:PL_LO]),
    .may_ie (may_ie),
    .may_pl (may_pl),
    .trap_ie(trap_ie)
  );

  psw_merge u_merge (
    .kind   (kind),
    .cur    (flags_q),
    .src    (src_word),
    .rest   (rest_word),
    .may_ie (may_ie),
    .may_pl (may_pl),
    .trap_ie(trap_ie),
    .nxt    (flags_d)
  );

  always_comb begin
    byte_en = accept && (op_in == OP_LDB);
    byte_d  = flags_q[BW-1:0] & XFER_MASK;
    done_d  = (accept && !go_pop) || pend_q;
    fault_d = accept && ((op_in == OP_STI) || (op_in == OP_CLI)) && trap_ie;
    sp_we_d = go_push || pend_q;
    sp_d    = pend_q ? pend_sp_q : (sp_cur - STEP_V);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_q <= '0;
      byte_q  <= '0;
      sp_q    <= '0;
      sp_we_q <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      if (byte_en) byte_q <= byte_d;
      if (sp_we_d) sp_q   <= sp_d;
      sp_we_q <= sp_we_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  assign flags    = flags_q;
  assign byte_out = byte_q;
  assign sp_next  = sp_q;
  assign sp_we    = sp_we_q;
  assign done     = done_q;
  assign fault    = fault_q;

endmodule

// File: rtl/psw_guard_chk.sv
module psw_guard_chk
  import psw_guard_pkg::*;
#(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          busy,
  input logic          start,
  input logic [2:0]    op,
  input logic [1:0]    cpl,
  input logic          prot_mode,
  input logic [AW-1:0] sp_cur,
  input logic [15:0]   flags,
  input logic [AW-1:0] sp_next,
  input logic          sp_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic          mem_we,
  input logic          mem_re,
  input logic          done,
  input logic          fault
);

  logic go;
  assign go = start && !busy;

  a_r4_push_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && op == OP_PUSH |-> mem_we && !mem_re && mem_addr == sp_cur - AW'(2) && mem_wdata == flags);

  a_r4_push_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && op == OP_PUSH |=> $stable(flags) && sp_we && done && sp_next == $past(sp_cur) - AW'(2));

  a_r5_pop_request: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && op == OP_POP |-> mem_re && !mem_we && mem_addr == sp_cur);

  a_r5_pop_wait: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && op == OP_POP |=> busy && !done && !sp_we);

  a_r6_pl_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && op == OP_IRET && prot_mode && cpl != 2'd0 |=> flags[13:12] == $past(flags[13:12]));

  a_r7_ie_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && op == OP_IRET && prot_mode && cpl > flags[13:12] |=> flags[9] == $past(flags[9]) && !fault);

  a_r8_trap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    go && (op == OP_STI || op == OP_CLI) && prot_mode && cpl > flags[13:12]
    |=> fault && done && $stable(flags));

  a_r8_fault_with_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault |-> done);

  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |-> !mem_we && !mem_re);

endmodule

bind psw_guard psw_guard_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .busy      (pend_q),
  .start     (start),
  .op        (op),
  .cpl       (cpl),
  .prot_mode (prot_mode),
  .sp_cur    (sp_cur),
  .flags     (flags),
  .sp_next   (sp_next),
  .sp_we     (sp_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .done      (done),
  .fault     (fault)
);

// File: tb/psw_guard_tb.sv
module psw_guard_tb;

  localparam int AW = 16;
  localparam int NV = 13;
  // {op[3], cpl[2], prot[1], src[16], exp_flags[16], exp_fault[1]}
  localparam logic [38:0] VEC [NV] = '{
    {3'd7, 2'd0, 1'b1, 16'h3FD5, 16'h3FD5, 1'b0},
    {3'd2, 2'd3, 1'b1, 16'h0000, 16'h3F00, 1'b0},
    {3'd6, 2'd3, 1'b1, 16'h0000, 16'h3D00, 1'b0},
    {3'd7, 2'd3, 1'b1, 16'h0000, 16'h3000, 1'b0},
    {3'd7, 2'd2, 1'b1, 16'h1200, 16'h3200, 1'b0},
    {3'd7, 2'd0, 1'b1, 16'h1000, 16'h1000, 1'b0},
    {3'd5, 2'd2, 1'b1, 16'h0000, 16'h1000, 1'b1},
    {3'd5, 2'd1, 1'b1, 16'h0000, 16'h1200, 1'b0},
    {3'd7, 2'd2, 1'b1, 16'h00FF, 16'h12FF, 1'b0},
    {3'd6, 2'd3, 1'b0, 16'h0000, 16'h10FF, 1'b0},
    {3'd7, 2'd3, 1'b0, 16'h2000, 16'h2000, 1'b0},
    {3'd5, 2'd3, 1'b1, 16'h0000, 16'h2000, 1'b1},
    {3'd2, 2'd0, 1'b0, 16'h00AA, 16'h2080, 1'b0}
  };

  logic          clk, rst_n, start, prot_mode, sp_we, mem_we, mem_re, done, fault;
  logic [2:0]    op;
  logic [1:0]    cpl;
  logic [15:0]   src_word, mem_rdata, flags, mem_wdata;
  logic [7:0]    byte_out;
  logic [AW-1:0] sp_cur, sp_next, mem_addr;
  logic [15:0]   mem [16];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  psw_guard #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cpl(cpl),
    .prot_mode(prot_mode), .src_word(src_word), .sp_cur(sp_cur),
    .mem_rdata(mem_rdata), .flags(flags), .byte_out(byte_out),
    .sp_next(sp_next), .sp_we(sp_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .done(done), .fault(fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[4:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[4:1]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] c, input logic p, input logic [15:0] s);
    @(negedge clk);
    start = 1'b1; op = o; cpl = c; prot_mode = p; src_word = s;
  endtask

  task automatic idle_next;
    @(negedge clk);
    start = 1'b0; op = 3'd0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 3'd0; cpl = 2'd0; prot_mode = 1'b0;
    src_word = 16'h0; sp_cur = 16'h0100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 flags", flags, 16'h0000);
    chk("R1 ie bit", flags[9], 1'b0);
    chk("R1 done/fault/sp_we", {done, fault, sp_we}, 3'b000);
    chk("R1 byte_out", byte_out, 8'h00);

    // Vector table: single-cycle ops (R3, R6, R7, R8)
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vo; string tag;
      vo = VEC[i][38:36];
      tag = (vo == 3'd2) ? "R3" : (vo == 3'd7) ? "R6 R7" : "R8";
      drive(vo, VEC[i][35:34], VEC[i][33], VEC[i][32:17]);
      idle_next();
      chk($sformatf("%s vec %0d flags", tag, i), flags, VEC[i][16:1]);
      chk($sformatf("%s vec %0d fault", tag, i), fault, VEC[i][0]);
      chk($sformatf("%s vec %0d done", tag, i), done, 1'b1);
    end

    // R2 byte-load
    drive(3'd7, 2'd0, 1'b0, 16'hFFFF);
    idle_next();
    drive(3'd1, 2'd3, 1'b1, 16'h0000);
    idle_next();
    chk("R2 byte_out", byte_out, 8'hD5);
    chk("R2 flags kept", flags, 16'hFFFF);
    chk("R2 done", done, 1'b1);

    // R4 push
    sp_cur = 16'h0100;
    drive(3'd3, 2'd3, 1'b1, 16'h0000);
    #1;
    chk("R4 mem_we", {mem_we, mem_re}, 2'b10);
    chk("R4 addr", mem_addr, 16'h00FE);
    chk("R4 wdata", mem_wdata, 16'hFFFF);
    idle_next();
    chk("R4 sp_next", sp_next, 16'h00FE);
    chk("R4 sp_we", {sp_we, done}, 2'b11);
    chk("R4 flags kept", flags, 16'hFFFF);

    // clear to zero, then pop from low privilege (R5, R6, R7, R9)
    drive(3'd7, 2'd0, 1'b0, 16'h0000);
    idle_next();
    chk("R6 R7 cleared", flags, 16'h0000);
    sp_cur = 16'h00FE;
    drive(3'd4, 2'd3, 1'b1, 16'h0000);
    #1;
    chk("R5 read request", {mem_re, mem_we}, 2'b10);
    chk("R5 read addr", mem_addr, 16'h00FE);
    @(negedge clk);
    // R9: strobe while pop pending, would set ie if accepted
    start = 1'b1; op = 3'd5; cpl = 2'd0; prot_mode = 1'b0;
    chk("R5 no early done", done, 1'b0);
    #1;
    chk("R9 no mem access", {mem_re, mem_we}, 2'b00);
    idle_next();
    chk("R5 done", done, 1'b1);
    chk("R5 sp_next", {sp_we, sp_next}, {1'b1, 16'h0100});
    chk("R6 R7 pop filtered", flags, 16'hCDFF);
    idle_next();
    chk("R9 no extra done", done, 1'b0);
    chk("R9 ie still clear", flags, 16'hCDFF);

    finish_run();
  end

endmodule